// File: doc/BRIEF.md
# Multi-Port Transmit Availability Status Generator

This block sits on the physical-layer side of a four-port transmit interface and tells the link-layer device whether each port's transmit FIFO can take more data. It watches each port's FIFO fill level, given in 32-bit words. From that level and a programmable threshold it keeps one availability flag per port. The flag follows one of two rule sets. In cell mode the rules count whole cells of a fixed word size. In packet mode they use an almost-full level counted in words. Each flag sets and clears at separate points and holds its value in between, so it has hysteresis.

The flags reach the link layer in three ways. Ports 2 to 4 each have a dedicated direct output. A shared output carries either port 1's flag (direct reporting) or the flag of the port named by a 5-bit poll address (polled reporting). A selected-port-available output is used in packet mode. The shared output and the selected-port output each have an output enable that stands for a tri-state driver. The enable follows the bus-level rules: at level 2 the shared output floats unless a real port is polled, and at level 3 it is always driven.

All outputs are registered. They reflect the inputs sampled at the previous rising edge of the transmit clock. The FIFOs, the configuration registers and the selection-phase address decode sit outside the block and arrive as plain inputs.

Top module: `tx_avail_status`

## Requirements
- R1: Every output changes only at a rising edge of `clk`, and shows the state computed from the inputs sampled at that same edge. An input change between edges leaves all outputs unchanged.
- R2: In cell mode (`pkt_mode`=0), free space is `DEPTH - fill`, taken as 0 when fill is at or above `DEPTH`. A port flag sets when free space is at least `(af_thresh+1)*CELL_WORDS` words. It clears when free space is below `CELL_WORDS` words.
- R3: In packet mode (`pkt_mode`=1), a port flag sets when free space is greater than `af_thresh` words. It clears only when free space is 0, meaning the FIFO is full.
- R4: When neither the set condition nor the clear condition holds, a port flag keeps its previous value. A fill level above `DEPTH` counts as full.
- R5: `dir_avail[p]` always shows the flag of port index p (p = 1..NPORTS-1, where index 0 is the first port). With `direct_en`=1, `stat_val` shows the flag of port 0 and `stat_oe` is 1.
- R6: With `direct_en`=0 (polled reporting), `stat_val` shows the flag of the port whose index equals `poll_addr`. It is 0 when `poll_addr` is NPORTS or more.
- R7: In polled reporting at level 2 (`bus_l3`=0), `stat_oe` is 1 only when `poll_addr` is below NPORTS and `dp_rst` is 0.
- R8: In polled reporting at level 3 (`bus_l3`=1), `stat_oe` is 1 whatever the values of `poll_addr` and `dp_rst`.
- R9: While `rst` (synchronous, active high) is sampled high, all flags clear, `stat_oe` and `spa_oe` are 0, and every data output is 0.
- R10: In packet mode `spa_oe` is 1. `spa_val` is 1 only when `sel_valid` is 1, `sel_addr` is below NPORTS, and that port's free space is greater than `af_thresh` words.
- R11: In cell mode `spa_val` and `spa_oe` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock, rising edge |
| rst | input | 1 | Global synchronous reset, active high |
| dp_rst | input | 1 | Data-path reset; floats the polled output at level 2 |
| fill_lvl | input | NPORTS*FILL_W | Per-port FIFO fill in words, port p at bits [p*FILL_W +: FILL_W] |
| af_thresh | input | THR_W | Threshold: whole cells in cell mode, words in packet mode |
| pkt_mode | input | 1 | 0 = cell mode, 1 = packet mode |
| bus_l3 | input | 1 | 0 = level-2 bus rules, 1 = level-3 bus rules |
| direct_en | input | 1 | 0 = polled reporting, 1 = direct reporting |
| poll_addr | input | ADDR_W | Address of the port being polled |
| sel_valid | input | 1 | A port is selected for transfer |
| sel_addr | input | ADDR_W | Address of the selected port |
| stat_val | output | 1 | Shared polled / port-1 direct availability |
| stat_oe | output | 1 | Output enable for stat_val |
| dir_avail | output | NPORTS-1 | Direct availability of ports index 1..NPORTS-1 |
| spa_val | output | 1 | Selected port can accept more than the almost-full level |
| spa_oe | output | 1 | Output enable for spa_val |

## Verification
Two events can land on the same clock edge. A port's flag can cross its set or clear point, and in that same cycle the poll address can move onto that port. The selected-port output can also look at the same port in that cycle. The sweep moves all four fill levels along offset triangle ramps while it steps the poll and select addresses on their own strides. Many edges therefore carry a flag transition on exactly the port being polled or selected. Each such edge is judged against a bench model that first updates every flag from the new fill and only then forms the polled and selected outputs. A design that reads the stale flag therefore fails.

// File: rtl/txav_pkg.sv
package txav_pkg;

    typedef enum logic { XFER_CELL = 1'b0, XFER_PKT  = 1'b1 } xfer_mode_e;
    typedef enum logic { BUS_LVL2  = 1'b0, BUS_LVL3  = 1'b1 } bus_level_e;
    typedef enum logic { RPT_POLL  = 1'b0, RPT_DIRECT = 1'b1 } report_e;

    // set / clear request for one availability flag
    typedef struct packed {
        logic set;
        logic clr;
    } flag_req_t;

    // value plus enable standing for a tri-state driver
    typedef struct packed {
        logic oe;
        logic val;
    } tri_out_t;

    // free words left in a FIFO, saturating at zero
    function automatic logic [31:0] free_words(input logic [31:0] fill,
                                               input logic [31:0] depth);
        return (fill >= depth) ? 32'd0 : depth - fill;
    endfunction

    function automatic flag_req_t cell_req(input logic [31:0] free,
                                           input logic [31:0] thr,
                                           input logic [31:0] cell_w);
        flag_req_t r;
        r.set = free >= (thr + 32'd1) * cell_w;
        r.clr = free < cell_w;
        return r;
    endfunction

    function automatic flag_req_t pkt_req(input logic [31:0] free,
                                          input logic [31:0] thr);
        flag_req_t r;
        r.set = free > thr;
        r.clr = (free == 32'd0);
        return r;
    endfunction

    function automatic logic next_flag(input flag_req_t r, input logic cur);
        if (r.set)      return 1'b1;
        else if (r.clr) return 1'b0;
        else            return cur;
    endfunction

endpackage

// File: rtl/txav_port_flag.sv
module txav_port_flag
    import txav_pkg::*;
#(
    parameter int FILL_W     = 7,
    parameter int DEPTH      = 64,
    parameter int CELL_WORDS = 4,
    parameter int THR_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill,
    input  logic [THR_W-1:0]  thr,
    input  xfer_mode_e        mode,
    output logic              flag_d,
    output logic              above_af
);

    logic [31:0] free;
    flag_req_t   req_cell;
    flag_req_t   req_pkt;
    flag_req_t   req;
    logic        flag_q;

    always_comb begin
        free     = free_words(32'(fill), 32'(DEPTH));
        req_cell = cell_req(free, 32'(thr), 32'(CELL_WORDS));
        req_pkt  = pkt_req(free, 32'(thr));
        req      = (mode == XFER_PKT) ? req_pkt : req_cell;
        flag_d   = next_flag(req, flag_q);
        above_af = req_pkt.set;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    // R3: a full FIFO always drops the flag in packet mode
    p_full_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_PKT && 32'(fill) >= 32'(DEPTH)) |=> !flag_q);

    // R2: no room for one whole cell drops the flag in cell mode
    p_cell_drops_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == XFER_CELL && 32'(fill) + 32'(CELL_WORDS) > 32'(DEPTH)) |=> !flag_q);

    // R4: inside the hysteresis band the flag holds
    p_hold_band_r4: assert property (@(posedge clk) disable iff (rst)
        (!req.set && !req.clr) |=> $stable(flag_q));

endmodule

// File: rtl/txav_poll_sel.sv
module txav_poll_sel
    import txav_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 5
) (
    input  logic [NPORTS-1:0] flags,
    input  report_e           rpt,
    input  bus_level_e        lvl,
    input  logic              dp_rst,
    input  logic [ADDR_W-1:0] poll_addr,
    output tri_out_t          nxt
);

    logic hit;
    logic hit_val;

    always_comb begin
        hit     = 1'b0;
        hit_val = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (poll_addr == ADDR_W'(i)) begin
                hit     = 1'b1;
                hit_val = flags[i];
            end
        end
        if (rpt == RPT_DIRECT) begin
            nxt.val = flags[0];
            nxt.oe  = 1'b1;
        end else begin
            nxt.val = hit_val;
            nxt.oe  = (lvl == BUS_LVL3) | (hit & ~dp_rst);
        end
    end

endmodule

// File: rtl/txav_spa_sel.sv
module txav_spa_sel
    import txav_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 5
) (
    input  logic [NPORTS-1:0] above_af,
    input  xfer_mode_e        mode,
    input  logic              sel_valid,
    input  logic [ADDR_W-1:0] sel_addr,
    output tri_out_t          nxt
);

    logic pick;

    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (sel_addr == ADDR_W'(i)) pick = above_af[i];
        end
        nxt.oe  = (mode == XFER_PKT);
        nxt.val = (mode == XFER_PKT) & sel_valid & pick;
    end

endmodule

// File: rtl/tx_avail_status.sv
module tx_avail_status
    import txav_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int FILL_W     = 7,
    parameter int DEPTH      = 64,
    parameter int CELL_WORDS = 4,
    parameter int THR_W      = 4,
    parameter int ADDR_W     = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dp_rst,
    input  logic [NPORTS*FILL_W-1:0] fill_lvl,
    input  logic [THR_W-1:0]         af_thresh,
    input  logic                     pkt_mode,
    input  logic                     bus_l3,
    input  logic                     direct_en,
    input  logic [ADDR_W-1:0]        poll_addr,
    input  logic                     sel_valid,
    input  logic [ADDR_W-1:0]        sel_addr,
    output logic                     stat_val,
    output logic                     stat_oe,
    output logic [NPORTS-1:1]        dir_avail,
    output logic                     spa_val,
    output logic                     spa_oe
);

    xfer_mode_e        mode;
    bus_level_e        lvl;
    report_e           rpt;
    logic [NPORTS-1:0] flags_d;
    logic [NPORTS-1:0] af_vec;
    tri_out_t          poll_nxt, spa_nxt;
    tri_out_t          stat_q, spa_q;
    logic [NPORTS-1:1] dir_q;

    assign mode = xfer_mode_e'(pkt_mode);
    assign lvl  = bus_level_e'(bus_l3);
    assign rpt  = report_e'(direct_en);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        txav_port_flag #(
            .FILL_W(FILL_W), .DEPTH(DEPTH),
            .CELL_WORDS(CELL_WORDS), .THR_W(THR_W)
        ) u_flag (
            .clk      (clk),
            .rst      (rst),
            .fill     (fill_lvl[p*FILL_W +: FILL_W]),
            .thr      (af_thresh),
            .mode     (mode),
            .flag_d   (flags_d[p]),
            .above_af (af_vec[p])
        );
    end

    txav_poll_sel #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_poll (
        .flags     (flags_d),
        .rpt       (rpt),
        .lvl       (lvl),
        .dp_rst    (dp_rst),
        .poll_addr (poll_addr),
        .nxt       (poll_nxt)
    );

    txav_spa_sel #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) u_spa (
        .above_af  (af_vec),
        .mode      (mode),
        .sel_valid (sel_valid),
        .sel_addr  (sel_addr),
        .nxt       (spa_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            spa_q  <= '0;
            dir_q  <= '0;
        end else begin
            stat_q <= poll_nxt;
            spa_q  <= spa_nxt;
            dir_q  <= flags_d[NPORTS-1:1];
        end
    end

    assign stat_val  = stat_q.val;
    assign stat_oe   = stat_q.oe;
    assign spa_val   = spa_q.val;
    assign spa_oe    = spa_q.oe;
    assign dir_avail = dir_q;

    // R9: global reset floats both shared outputs and clears direct flags
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!stat_oe && !spa_oe && dir_avail == '0));

    // R8: level-3 polled output always driven
    p_l3_driven_r8: assert property (@(posedge clk) disable iff (rst)
        (!direct_en && bus_l3) |=> stat_oe);

    // R7: level-2 polled output floats with no valid port or data-path reset
    p_l2_float_r7: assert property (@(posedge clk) disable iff (rst)
        (!direct_en && !bus_l3 && (dp_rst || 32'(poll_addr) >= 32'(NPORTS)))
        |=> !stat_oe);

    // R5: direct reporting always drives the shared output
    p_direct_driven_r5: assert property (@(posedge clk) disable iff (rst)
        direct_en |=> stat_oe);

    // R11: selected-port output is idle in cell mode
    p_spa_cell_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !pkt_mode |=> (!spa_oe && !spa_val));

    // R10: without a selection the selected-port output stays low
    p_spa_needs_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_mode && !sel_valid) |=> (spa_oe && !spa_val));

endmodule

// File: tb/tx_avail_status_bench.sv
`timescale 1ns/1ps
module tx_avail_status_bench;

    localparam int NP    = 4;
    localparam int FW    = 7;
    localparam int DEPTH = 64;
    localparam int CW    = 4;
    localparam int TW    = 4;
    localparam int AW    = 5;

    logic            clk = 1'b0;
    logic            rst, dp_rst, pkt_mode, bus_l3, direct_en, sel_valid;
    logic [NP*FW-1:0] fill_lvl;
    logic [TW-1:0]   af_thresh;
    logic [AW-1:0]   poll_addr, sel_addr;
    logic            stat_val, stat_oe, spa_val, spa_oe;
    logic [NP-1:1]   dir_avail;

    int f [NP];
    logic [NP-1:0] mflag;
    logic [NP-1:0] mabove;
    logic e_stat, e_soe, e_spa, e_spoe;
    logic [NP-1:1] e_dir;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tx_avail_status #(
        .NPORTS(NP), .FILL_W(FW), .DEPTH(DEPTH),
        .CELL_WORDS(CW), .THR_W(TW), .ADDR_W(AW)
    ) u_tx_avail_status (
        .clk(clk), .rst(rst), .dp_rst(dp_rst), .fill_lvl(fill_lvl),
        .af_thresh(af_thresh), .pkt_mode(pkt_mode), .bus_l3(bus_l3),
        .direct_en(direct_en), .poll_addr(poll_addr), .sel_valid(sel_valid),
        .sel_addr(sel_addr), .stat_val(stat_val), .stat_oe(stat_oe),
        .dir_avail(dir_avail), .spa_val(spa_val), .spa_oe(spa_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_fill();
        for (int p = 0; p < NP; p++) fill_lvl[p*FW +: FW] = FW'(f[p]);
    endtask

    // model update from the requirements, applied at one rising edge
    task automatic model_edge();
        if (rst) begin
            mflag = '0;
            e_stat = 0; e_soe = 0; e_spa = 0; e_spoe = 0; e_dir = '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                int free;
                bit set, clr;
                free = (f[p] >= DEPTH) ? 0 : DEPTH - f[p];
                if (pkt_mode) begin
                    set = free > int'(af_thresh);
                    clr = (free == 0);
                end else begin
                    set = free >= (int'(af_thresh) + 1) * CW;
                    clr = free < CW;
                end
                mabove[p] = free > int'(af_thresh);
                if (set) mflag[p] = 1'b1;
                else if (clr) mflag[p] = 1'b0;
            end
            if (direct_en) begin
                e_stat = mflag[0];
                e_soe  = 1'b1;
            end else begin
                e_stat = (int'(poll_addr) < NP) ? mflag[poll_addr] : 1'b0;
                e_soe  = bus_l3 | ((int'(poll_addr) < NP) & ~dp_rst);
            end
            e_spoe = pkt_mode;
            e_spa  = pkt_mode & sel_valid & (int'(sel_addr) < NP) &&
                     mabove[sel_addr];
            e_dir  = mflag[NP-1:1];
        end
    endtask

    task automatic step();
        load_fill();
        @(posedge clk);
        model_edge();
        #1;
        chk(rst ? "R9" : (pkt_mode ? "R3/R4 dir_avail" : "R2/R4 dir_avail"),
            32'(dir_avail), 32'(e_dir));
        chk(rst ? "R9" : (direct_en ? "R5 stat_val" : "R6 stat_val"),
            32'(stat_val), 32'(e_stat));
        chk(rst ? "R9" : (direct_en ? "R5 stat_oe" : (bus_l3 ? "R8 stat_oe" : "R7 stat_oe")),
            32'(stat_oe), 32'(e_soe));
        chk(rst ? "R9" : (pkt_mode ? "R10 spa" : "R11 spa"),
            32'({spa_oe, spa_val}), 32'({e_spoe, e_spa}));
    endtask

    function automatic int tri_wave(input int x);
        int m;
        m = x % 144;
        return (m <= 72) ? m : 144 - m;
    endfunction

    initial begin
        int thr_set [4] = '{0, 1, 3, 15};
        rst = 1; dp_rst = 0; pkt_mode = 0; bus_l3 = 0; direct_en = 0;
        sel_valid = 0; af_thresh = '0; poll_addr = '0; sel_addr = '0;
        for (int p = 0; p < NP; p++) f[p] = 0;
        mflag = '0; mabove = '0;
        fill_lvl = '0;
        // R9: reset state
        for (int k = 0; k < 3; k++) step();
        rst = 0;

        // sweep: fills on offset triangle ramps, addresses on own strides
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++)
                for (int ti = 0; ti < 4; ti++)
                    for (int i = 0; i < 144; i++) begin
                        for (int p = 0; p < NP; p++) f[p] = tri_wave(i + 37 * p);
                        pkt_mode  = m[0];
                        direct_en = d[0];
                        af_thresh = TW'(thr_set[ti]);
                        poll_addr = AW'((i * 5 + ti) % 32);
                        sel_addr  = AW'((i * 3 + m) % 32);
                        sel_valid = i[1];
                        bus_l3    = i[4];
                        dp_rst    = (i % 7 == 3);
                        step();
                    end

        // R1: change between edges has no effect until the next edge
        pkt_mode = 1; direct_en = 1; af_thresh = '0;
        for (int p = 0; p < NP; p++) f[p] = 0;
        step();
        for (int p = 0; p < NP; p++) f[p] = DEPTH;
        load_fill();
        #1;
        chk("R1 dir_avail held between edges", 32'(dir_avail), 32'(3'b111));
        chk("R1 stat_val held between edges", 32'(stat_val), 32'(1));
        step();

        // R9 mid-run reset clears flags; band fill then keeps them low (R4)
        for (int p = 0; p < NP; p++) f[p] = 0;
        step();
        rst = 1;
        step();
        rst = 0;
        af_thresh = TW'(8);
        for (int p = 0; p < NP; p++) f[p] = 60;
        step();
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule